// File: doc/BRIEF.md
# Manchester II Framed Word Encoder

This block turns one parallel data word into a bi-phase (Manchester II) serial frame for a command/response style twisted-pair bus. Every frame opens with a three-bit-period synchronisation pattern, continues with a data field whose length is programmable from 2 to 28 bits, and closes with a single parity bit. The line is presented as a pair of complementary drive signals, one for a high line level and one for a low line level, which a line driver would turn into the differential bus waveform.

The encoder runs from a fast encoder clock. A free-running prescaler divides it by six to form the half-bit timing and exposes that divided clock on a pin. A further divide-by-two gives the bit-rate send clock. The host presents a word, a length, the sync type and the parity sense, then raises the enable. The enable is only looked at on half-bit boundaries while no frame is running, or on the boundary that ends the last half of a frame, so frames can run back to back. A busy flag covers the data bits, and a one-clock strobe marks the start of each data bit. An inhibit input silences both line outputs without disturbing the framing. A master reset returns everything to idle.

Top module: `manchester_frame_encoder`

## Requirements
- R1: A half-bit period lasts exactly 6 encoder clocks and a bit period 12. A frame with N data bits lasts 6 + 2N + 2 half-bit periods, after which both line outputs and busy are low unless a new frame starts.
- R2: With `sync_cmd`=1 the sync field is high (bip_one=1) for its first three half-bits and low (bip_zero=1) for the next three; with `sync_cmd`=0 it is low for three half-bits and then high for three.
- R3: During a frame exactly one of bip_one and bip_zero is high (bip_one means line high). Data bits go out most significant first, taken from `data_in[N-1:0]` with bit N-1 first. A one is high in its first half and low in its second; a zero is the reverse.
- R4: `word_len` gives N directly for values 2 to 28. Values 0 and 1 act as 2, and 29 to 31 act as 28. Bits of `data_in` at or above N are never sent.
- R5: The parity bit follows the data in the last bit period, encoded the same way as a data bit. With `parity_odd`=0 the data bits plus parity hold an even number of ones, and with `parity_odd`=1 an odd number.
- R6: With no frame running, both line outputs and busy are low. A raised enable starts a frame within 6 clocks. Word, length, sync type and parity sense are captured at the start, and changing them during a frame has no effect on it. If enable is high at the boundary that ends a frame, the next frame begins at once with no idle gap.
- R7: `busy` is high exactly during the 2N data half-bits. `shift_stb` is a one-clock pulse at the first clock of each data bit, giving N pulses per frame.
- R8: `inhibit`=1 forces both line outputs low in the same cycle, while framing, busy and strobes continue. Releasing it brings back the current line level at once.
- R9: `div6_out` is a square wave of period 6 clocks (3 high, 3 low). `send_clk` has period 12 clocks (6 high, 6 low) and changes only when `div6_out` also changes.
- R10: A low `rst_n` at once drives the line outputs, busy, strobe, `div6_out` and `send_clk` low and abandons any frame. Release takes effect on the clock edges that follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Encoder clock |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| enable | input | 1 | Request to send a frame |
| word_len | input | 5 | Data field length in bits (clamped to 2..28) |
| data_in | input | 28 | Parallel data word, bit N-1 sent first |
| sync_cmd | input | 1 | 1 selects command sync, 0 selects data sync |
| parity_odd | input | 1 | 1 selects odd parity, 0 even parity |
| inhibit | input | 1 | Forces both line outputs low |
| bip_one | output | 1 | Line-high drive |
| bip_zero | output | 1 | Line-low drive |
| busy | output | 1 | High while data bits are on the line |
| shift_stb | output | 1 | One-clock pulse at the start of each data bit |
| div6_out | output | 1 | Encoder clock divided by six |
| send_clk | output | 1 | Bit-rate send clock (encoder clock divided by twelve) |

## Verification
The one place where two functions meet in a single cycle is the half-bit boundary that closes the parity bit: there the running frame must end and, with enable still high, a new frame must be captured and begin its sync. The bench provokes this by holding enable through a whole frame while putting a second, different word, length, sync type and parity sense on the inputs. It then checks every clock of both frames against independently computed levels, so the first frame must keep its captured fields to the last half-bit and the second must start in the very next clock with no gap. The same run also shows that the mid-frame input changes are ignored.

// File: rtl/mfe_pkg.sv
package mfe_pkg;

  // Sync field length in half-bit periods and the half-bit where it flips.
  localparam int unsigned SYNC_HALVES = 6;
  localparam int unsigned SYNC_SPLIT  = 3;

  typedef enum logic [1:0] {
    PH_SYNC   = 2'd0,
    PH_DATA   = 2'd1,
    PH_PARITY = 2'd2
  } frame_phase_e;

endpackage

// File: rtl/mfe_clkdiv.sv
module mfe_clkdiv #(
  parameter int unsigned PRE_DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic half_tick,
  output logic half_first,
  output logic div_out,
  output logic send_clk
);

  localparam int unsigned CNT_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int unsigned MID   = PRE_DIV / 2;

  logic [CNT_W-1:0] pre_cnt_q, pre_cnt_d;
  logic             div_q, div_d;
  logic             bitclk_q, bitclk_d;
  logic             at_mid;

  assign half_tick  = (pre_cnt_q == CNT_W'(PRE_DIV - 1));
  assign at_mid     = (pre_cnt_q == CNT_W'(MID - 1));
  assign half_first = (pre_cnt_q == '0);

  always_comb begin
    pre_cnt_d = half_tick ? '0 : pre_cnt_q + CNT_W'(1);
    div_d     = (half_tick || at_mid) ? ~div_q : div_q;
    bitclk_d  = half_tick ? ~bitclk_q : bitclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt_q <= '0;
      div_q     <= 1'b0;
      bitclk_q  <= 1'b0;
    end else begin
      pre_cnt_q <= pre_cnt_d;
      div_q     <= div_d;
      bitclk_q  <= bitclk_d;
    end
  end

  assign div_out  = div_q;
  assign send_clk = bitclk_q;

endmodule

// File: rtl/mfe_sequencer.sv
module mfe_sequencer
  import mfe_pkg::*;
#(
  parameter int unsigned MAX_BITS = 28,
  parameter int unsigned MIN_BITS = 2,
  parameter int unsigned LEN_W    = 5,
  parameter int unsigned IDX_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                half_tick,
  input  logic                half_first,
  input  logic                enable,
  input  logic [LEN_W-1:0]    word_len,
  input  logic [MAX_BITS-1:0] data_in,
  input  logic                sync_cmd,
  input  logic                parity_odd,
  output logic                active,
  output logic [IDX_W-1:0]    half_idx,
  output frame_phase_e        phase,
  output logic [MAX_BITS-1:0] word_q,
  output logic [LEN_W-1:0]    len_q,
  output logic                sync_q,
  output logic                par_q,
  output logic                busy,
  output logic                shift_stb
);

  logic                active_q, active_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [MAX_BITS-1:0] word_d;
  logic [LEN_W-1:0]    len_d;
  logic                sync_d, par_d;
  logic [MAX_BITS-1:0] word_qr;
  logic [LEN_W-1:0]    len_qr;
  logic                sync_qr, par_qr;

  logic [LEN_W-1:0]    eff_len;
  logic [MAX_BITS-1:0] len_mask;
  logic                par_calc;
  logic [IDX_W-1:0]    data_end, last_idx;
  logic                at_last, start;

  // Clamp the requested length into the legal range.
  always_comb begin
    if (word_len < LEN_W'(MIN_BITS))      eff_len = LEN_W'(MIN_BITS);
    else if (word_len > LEN_W'(MAX_BITS)) eff_len = LEN_W'(MAX_BITS);
    else                                  eff_len = word_len;
  end

  // One mask bit per data position that belongs to the field.
  for (genvar gi = 0; gi < MAX_BITS; gi++) begin : g_mask
    assign len_mask[gi] = (eff_len > LEN_W'(gi));
  end

  assign par_calc = (^(data_in & len_mask)) ^ parity_odd;

  assign data_end = IDX_W'(SYNC_HALVES) + (IDX_W'(len_qr) << 1);
  assign last_idx = data_end + IDX_W'(1);
  assign at_last  = active_q && (idx_q == last_idx);
  assign start    = half_tick && enable && (!active_q || at_last);

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    word_d   = word_qr;
    len_d    = len_qr;
    sync_d   = sync_qr;
    par_d    = par_qr;
    if (half_tick) begin
      if (start) begin
        active_d = 1'b1;
        idx_d    = '0;
        word_d   = data_in;
        len_d    = eff_len;
        sync_d   = sync_cmd;
        par_d    = par_calc;
      end else if (at_last) begin
        active_d = 1'b0;
        idx_d    = '0;
      end else if (active_q) begin
        idx_d    = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      word_qr  <= '0;
      len_qr   <= LEN_W'(MIN_BITS);
      sync_qr  <= 1'b0;
      par_qr   <= 1'b0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      word_qr  <= word_d;
      len_qr   <= len_d;
      sync_qr  <= sync_d;
      par_qr   <= par_d;
    end
  end

  always_comb begin
    if (idx_q < IDX_W'(SYNC_HALVES)) phase = PH_SYNC;
    else if (idx_q < data_end)       phase = PH_DATA;
    else                             phase = PH_PARITY;
  end

  assign active    = active_q;
  assign half_idx  = idx_q;
  assign word_q    = word_qr;
  assign len_q     = len_qr;
  assign sync_q    = sync_qr;
  assign par_q     = par_qr;
  assign busy      = active_q && (phase == PH_DATA);
  assign shift_stb = busy && half_first && !idx_q[0];

endmodule

// File: rtl/mfe_bitgen.sv
module mfe_bitgen
  import mfe_pkg::*;
#(
  parameter int unsigned MAX_BITS = 28,
  parameter int unsigned LEN_W    = 5,
  parameter int unsigned IDX_W    = 6
) (
  input  logic                active,
  input  logic [IDX_W-1:0]    half_idx,
  input  frame_phase_e        phase,
  input  logic [MAX_BITS-1:0] word_q,
  input  logic [LEN_W-1:0]    len_q,
  input  logic                sync_q,
  input  logic                par_q,
  input  logic                inhibit,
  output logic                bip_one,
  output logic                bip_zero
);

  logic [IDX_W-1:0] data_ofs;
  logic [LEN_W-1:0] bit_k, bit_pos;
  logic             bit_val, level, drive;

  assign data_ofs = half_idx - IDX_W'(SYNC_HALVES);
  assign bit_k    = LEN_W'(data_ofs >> 1);
  assign bit_pos  = len_q - bit_k - LEN_W'(1);
  assign bit_val  = word_q[bit_pos];

  // Second half of every bit cell is the complement of the first.
  always_comb begin
    unique case (phase)
      PH_SYNC:   level = sync_q ? (half_idx < IDX_W'(SYNC_SPLIT))
                                : (half_idx >= IDX_W'(SYNC_SPLIT));
      PH_DATA:   level = bit_val ^ half_idx[0];
      PH_PARITY: level = par_q ^ half_idx[0];
      default:   level = 1'b0;
    endcase
  end

  assign drive    = active && !inhibit;
  assign bip_one  = drive && level;
  assign bip_zero = drive && !level;

endmodule

// File: rtl/manchester_frame_encoder.sv
module manchester_frame_encoder
  import mfe_pkg::*;
#(
  parameter int unsigned MAX_BITS = 28,
  parameter int unsigned MIN_BITS = 2,
  parameter int unsigned LEN_W    = 5,
  parameter int unsigned PRE_DIV  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [LEN_W-1:0]    word_len,
  input  logic [MAX_BITS-1:0] data_in,
  input  logic                sync_cmd,
  input  logic                parity_odd,
  input  logic                inhibit,
  output logic                bip_one,
  output logic                bip_zero,
  output logic                busy,
  output logic                shift_stb,
  output logic                div6_out,
  output logic                send_clk
);

  localparam int unsigned MAX_HALVES = SYNC_HALVES + 2 * MAX_BITS + 2;
  localparam int unsigned IDX_W      = $clog2(MAX_HALVES);

  logic                rst_meta_q, rst_sync_n;
  logic                half_tick, half_first;
  logic                active, sync_q, par_q;
  logic [IDX_W-1:0]    half_idx;
  frame_phase_e        phase;
  logic [MAX_BITS-1:0] word_q;
  logic [LEN_W-1:0]    len_q;

  // Reset asserts at once and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  mfe_clkdiv #(.PRE_DIV(PRE_DIV)) u_clkdiv (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .half_tick  (half_tick),
    .half_first (half_first),
    .div_out    (div6_out),
    .send_clk   (send_clk)
  );

  mfe_sequencer #(
    .MAX_BITS (MAX_BITS),
    .MIN_BITS (MIN_BITS),
    .LEN_W    (LEN_W),
    .IDX_W    (IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .half_tick  (half_tick),
    .half_first (half_first),
    .enable     (enable),
    .word_len   (word_len),
    .data_in    (data_in),
    .sync_cmd   (sync_cmd),
    .parity_odd (parity_odd),
    .active     (active),
    .half_idx   (half_idx),
    .phase      (phase),
    .word_q     (word_q),
    .len_q      (len_q),
    .sync_q     (sync_q),
    .par_q      (par_q),
    .busy       (busy),
    .shift_stb  (shift_stb)
  );

  mfe_bitgen #(
    .MAX_BITS (MAX_BITS),
    .LEN_W    (LEN_W),
    .IDX_W    (IDX_W)
  ) u_bitgen (
    .active   (active),
    .half_idx (half_idx),
    .phase    (phase),
    .word_q   (word_q),
    .len_q    (len_q),
    .sync_q   (sync_q),
    .par_q    (par_q),
    .inhibit  (inhibit),
    .bip_one  (bip_one),
    .bip_zero (bip_zero)
  );

endmodule

// File: rtl/mfe_checker.sv
module mfe_checker (
  input logic clk,
  input logic rst_n,
  input logic inhibit,
  input logic bip_one,
  input logic bip_zero,
  input logic busy,
  input logic shift_stb,
  input logic div_out,
  input logic send_clk,
  input logic half_first
);

  AST_LINES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bip_one && bip_zero)); // R3

  AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> (!bip_one && !bip_zero)); // R8

  AST_STROBE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> busy); // R7

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |=> !shift_stb); // R7

  AST_BUSY_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(busy) |-> half_first); // R7

  AST_LINES_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    ((!$stable(bip_one) || !$stable(bip_zero)) && $stable(inhibit)) |-> half_first); // R1

  AST_DIV_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_out) |=> $stable(div_out)); // R9

  AST_SENDCLK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(send_clk) |-> !$stable(div_out)); // R9

endmodule

bind manchester_frame_encoder mfe_checker u_mfe_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .inhibit    (inhibit),
  .bip_one    (bip_one),
  .bip_zero   (bip_zero),
  .busy       (busy),
  .shift_stb  (shift_stb),
  .div_out    (div6_out),
  .send_clk   (send_clk),
  .half_first (half_first)
);

// File: tb/manchester_frame_encoder_test.sv
module manchester_frame_encoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [4:0]  word_len;
  logic [27:0] data_in;
  logic        sync_cmd, parity_odd, inhibit;
  logic        bip_one, bip_zero, busy, shift_stb, div6_out, send_clk;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  manchester_frame_encoder uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .word_len   (word_len),
    .data_in    (data_in),
    .sync_cmd   (sync_cmd),
    .parity_odd (parity_odd),
    .inhibit    (inhibit),
    .bip_one    (bip_one),
    .bip_zero   (bip_zero),
    .busy       (busy),
    .shift_stb  (shift_stb),
    .div6_out   (div6_out),
    .send_clk   (send_clk)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int eff_len(input int l);
    if (l < 2) return 2;
    if (l > 28) return 28;
    return l;
  endfunction

  function automatic bit exp_level(input logic [27:0] w, input int n, input bit cmd,
                                   input bit odd, input int h);
    if (h < 6) begin
      return cmd ? (h < 3) : (h >= 3);
    end else if (h < 6 + 2 * n) begin
      int k;
      bit b;
      k = (h - 6) / 2;
      b = w[n - 1 - k];
      return (h % 2 == 0) ? b : !b;
    end else begin
      bit p;
      p = odd;
      for (int i = 0; i < n; i++) p ^= w[i];
      return (h % 2 == 0) ? p : !p;
    end
  endfunction

  task automatic idle_check(input string req);
    chk(req, "bip_one idle", int'(bip_one), 0);
    chk(req, "bip_zero idle", int'(bip_zero), 0);
    chk(req, "busy idle", int'(busy), 0);
  endtask

  // Drive a request and stop at the first clock of the sync field.
  task automatic start_frame(input logic [27:0] w, input logic [4:0] len, input bit cmd,
                             input bit odd, input bit keep);
    int lat;
    bit found;
    @(negedge clk);
    data_in = w; word_len = len; sync_cmd = cmd; parity_odd = odd; enable = 1'b1;
    lat = 0; found = 1'b0;
    while (!found && lat < 10) begin
      @(negedge clk);
      lat++;
      if (bip_one || bip_zero) found = 1'b1;
    end
    chk("R6", "start within 6 clocks", int'(found && lat <= HALF), 1);
    if (!keep) enable = 1'b0;
  endtask

  // Check every clock of one frame; leaves at the clock after its last half.
  task automatic check_frame(input logic [27:0] w, input logic [4:0] len, input bit cmd,
                             input bit odd, input bit scramble);
    int n, t, stb;
    n = eff_len(int'(len));
    t = 6 + 2 * n + 2;
    stb = 0;
    for (int c = 0; c < t * HALF; c++) begin
      int h;
      bit lv;
      string tag;
      h = c / HALF;
      if (c == 1 && scramble) begin
        data_in = $urandom; word_len = 5'($urandom % 32);
        sync_cmd = 1'($urandom); parity_odd = 1'($urandom);
      end
      if (shift_stb) stb++;
      lv = exp_level(w, n, cmd, odd, h);
      tag = (h < 6) ? "R2" : ((h < 6 + 2 * n) ? "R3" : "R5");
      chk(tag, "bip_one", int'(bip_one), int'(lv));
      chk(tag, "bip_zero", int'(bip_zero), int'(!lv));
      chk("R7", "busy", int'(busy), int'(h >= 6 && h < 6 + 2 * n));
      @(negedge clk);
    end
    chk("R4", "strobes per frame", stb, n);
  endtask

  logic [27:0] wa, wb;
  logic [4:0]  la, lb;
  bit          ca, cb, oa, ob;
  bit          dsamp [24];
  bit          ssamp [24];
  int          guard;

  initial begin
    void'($urandom(32'd7031));
    rst_n = 1'b0; enable = 1'b0; word_len = 5'd8; data_in = '0;
    sync_cmd = 1'b0; parity_odd = 1'b0; inhibit = 1'b0;
    repeat (4) @(negedge clk);
    idle_check("R10");
    chk("R10", "div6_out in reset", int'(div6_out), 0);
    chk("R10", "send_clk in reset", int'(send_clk), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9: divider waveforms
    for (int i = 0; i < 24; i++) begin
      dsamp[i] = div6_out; ssamp[i] = send_clk;
      @(negedge clk);
    end
    for (int i = 0; i < 12; i++) begin
      chk("R9", "div6 half period", int'(dsamp[i] != dsamp[i + 3]), 1);
      chk("R9", "div6 period", int'(dsamp[i] == dsamp[i + 6]), 1);
      chk("R9", "send_clk half period", int'(ssamp[i] != ssamp[i + 6]), 1);
    end

    // Directed corner frames: longest, shortest, clamps, masking, all ones/zeros
    start_frame(28'hABCDEF1, 5'd28, 1'b1, 1'b0, 1'b0);
    check_frame(28'hABCDEF1, 5'd28, 1'b1, 1'b0, 1'b1);
    idle_check("R1");
    start_frame(28'h0000002, 5'd2, 1'b0, 1'b1, 1'b0);
    check_frame(28'h0000002, 5'd2, 1'b0, 1'b1, 1'b1);
    idle_check("R1");
    start_frame(28'hFFFFFF1, 5'd0, 1'b1, 1'b1, 1'b0);   // R4 clamp up
    check_frame(28'hFFFFFF1, 5'd0, 1'b1, 1'b1, 1'b1);
    idle_check("R4");
    start_frame(28'hFFFFFFF, 5'd31, 1'b0, 1'b0, 1'b0);  // R4 clamp down
    check_frame(28'hFFFFFFF, 5'd31, 1'b0, 1'b0, 1'b1);
    idle_check("R4");
    start_frame(28'hFFFFFF6, 5'd5, 1'b1, 1'b0, 1'b0);   // R4 upper bits unused
    check_frame(28'hFFFFFF6, 5'd5, 1'b1, 1'b0, 1'b1);
    idle_check("R6");
    start_frame(28'h0000000, 5'd16, 1'b0, 1'b0, 1'b0);  // R5 even parity of zeros
    check_frame(28'h0000000, 5'd16, 1'b0, 1'b0, 1'b1);
    idle_check("R6");

    // Random frames
    for (int r = 0; r < 20; r++) begin
      wa = $urandom; la = 5'($urandom % 32); ca = 1'($urandom); oa = 1'($urandom);
      start_frame(wa, la, ca, oa, 1'b0);
      check_frame(wa, la, ca, oa, 1'b1);
      idle_check("R1");
    end

    // R6: back-to-back frames, new request captured on the closing boundary
    wa = 28'h5A5A5A5; la = 5'd12; ca = 1'b1; oa = 1'b1;
    wb = 28'h0F0F0F0; lb = 5'd3;  cb = 1'b0; ob = 1'b0;
    start_frame(wa, la, ca, oa, 1'b1);
    data_in = wb; word_len = lb; sync_cmd = cb; parity_odd = ob;
    check_frame(wa, la, ca, oa, 1'b0);
    enable = 1'b0;
    check_frame(wb, lb, cb, ob, 1'b0);
    idle_check("R6");

    // R8: inhibit silences lines while framing continues
    @(negedge clk);
    inhibit = 1'b1; data_in = 28'h3C3C3C3; word_len = 5'd10;
    sync_cmd = 1'b1; parity_odd = 1'b0; enable = 1'b1;
    guard = 0;
    while (!busy && guard < 80) begin @(negedge clk); guard++; end
    chk("R8", "busy under inhibit", int'(busy), 1);
    enable = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R8", "bip_one inhibited", int'(bip_one), 0);
      chk("R8", "bip_zero inhibited", int'(bip_zero), 0);
      @(negedge clk);
    end
    inhibit = 1'b0;
    #1;
    chk("R8", "line back after release", int'(bip_one ^ bip_zero), 1);
    @(negedge clk);
    inhibit = 1'b1;
    #1;
    chk("R8", "bip_one cut at once", int'(bip_one), 0);
    chk("R8", "bip_zero cut at once", int'(bip_zero), 0);
    @(negedge clk);
    inhibit = 1'b0;
    guard = 0;
    while ((bip_one || bip_zero || busy) && guard < 600) begin @(negedge clk); guard++; end
    idle_check("R8");

    // R10: reset in the middle of a frame
    start_frame(28'h1234567, 5'd20, 1'b0, 1'b1, 1'b0);
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    #1;
    idle_check("R10");
    chk("R10", "shift_stb in reset", int'(shift_stb), 0);
    chk("R10", "div6_out in reset", int'(div6_out), 0);
    chk("R10", "send_clk in reset", int'(send_clk), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    idle_check("R10");
    start_frame(28'h0000ACE, 5'd12, 1'b1, 1'b1, 1'b0);
    check_frame(28'h0000ACE, 5'd12, 1'b1, 1'b1, 1'b0);
    idle_check("R10");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule